// File: doc/BRIEF.md
# Low-Power DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-power DDR SDRAM and brings the device from power-on to a usable state. Once the board indicates that supply and clock are stable, it waits out the power-up hold with the clock enable low and only NOP on the command bus. It then raises the clock enable and issues, in a fixed order, an all-bank precharge, two auto-refresh commands, a load of the mode register and a load of the extended mode register. A minimum gap is kept after each of these commands.

Burst length, burst type and CAS latency come in as configuration fields, and the block packs them into the mode-register word. The extended-mode word is passed through unchanged. All waits are parameters counted in clock cycles. When the final wait has expired, the block raises `init_done` and stays in that state. From then on, the command, address, bank-address and data-enable outputs follow the normal controller's inputs directly. An asserted reset restarts the whole sequence at any time.

Top module: `lpddr_init_seq`

## Requirements
- R1: While reset is asserted, and afterwards until the stable flag has been seen, the outputs are `cke`=0, `cmd`=NOP, `addr`=0, `ba`=0, `dq_oe`=0 and `init_done`=0. The command codes are NOP=0, PRECHARGE=1, AUTO REFRESH=2, MODE REGISTER SET=3 and ACTIVE=4.
- R2: If `pwr_ok` is low the block keeps waiting with no time limit. The first clock edge that samples `pwr_ok` high starts a hold of exactly `T_PWR` cycles, during which `cke` stays 0 and `cmd` stays NOP.
- R3: After the hold, `cke` rises and exactly one NOP cycle follows with `cke` high. PRECHARGE comes next with `addr[10]`=1, all other address bits 0 and `ba`=0.
- R4: Every command of the sequence lasts one cycle, with NOP on all cycles in between. The first AUTO REFRESH comes `T_RP` cycles after PRECHARGE.
- R5: The second AUTO REFRESH comes `T_RFC` cycles after the first. The mode-register load comes `T_RFC` cycles after the second.
- R6: The mode-register load is a MODE REGISTER SET with `ba`=0. Its address carries burst length in bits 2..0, burst type in bit 3 (0 sequential, 1 interleave) and CAS latency in bits 6..4. Every higher address bit is 0.
- R7: The extended-mode load comes `T_MRD` cycles after the mode-register load. It is a MODE REGISTER SET with `ba[1]`=1 and `ba[0]`=0, and its address equals `cfg_ext_word`.
- R8: `init_done` rises exactly `T_MRD` cycles after the extended-mode load and stays high until reset. `dq_oe` is 0 whenever `init_done` is 0. Once `cke` has risen it stays high.
- R9: While `init_done` is high, `cmd`, `addr`, `ba` and `dq_oe` equal `host_cmd`, `host_addr`, `host_ba` and `host_dq_oe` in the same cycle, and `cke` is 1. `pwr_ok` has no effect in this state.
- R10: Reset asserted at any step immediately returns the outputs to the R1 state. After release the full sequence runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_ok | input | 1 | Supply and clock are stable |
| cfg_burst_len | input | 3 | Burst-length field of the mode word |
| cfg_burst_type | input | 1 | Burst type, 0 sequential, 1 interleave |
| cfg_cas_lat | input | 3 | CAS-latency field of the mode word |
| cfg_ext_word | input | ADDR_W | Extended-mode register contents |
| host_cmd | input | 3 | Command from the normal controller |
| host_addr | input | ADDR_W | Address from the normal controller |
| host_ba | input | BA_W | Bank address from the normal controller |
| host_dq_oe | input | 1 | Data-bus enable from the normal controller |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 3 | Encoded command to the memory |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| dq_oe | output | 1 | Data/strobe output enable, 0 during initialization |
| init_done | output | 1 | Initialization complete, outputs handed over |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a wait or on the single cycle of a command, followed by a clean rerun. The bench therefore draws a random sample index inside the sequence for about half of its runs and asserts reset exactly there. It then checks the idle outputs at once and runs the full sequence again. The exact gaps between commands are the other target. Every command is matched to the sample index that the bench computes from the timing parameters, so a gap that is one cycle long or short shows up.

// File: rtl/lpddr_init_pkg.sv
`timescale 1ns/1ps
package lpddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PRE  = 3'd1,
    CMD_REF  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_ACT  = 3'd4
  } mem_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_CKE, S_PRE, S_RP,
    S_REF1, S_RFC1, S_REF2, S_RFC2,
    S_MRS,  S_MRD1, S_EMRS, S_MRD2, S_DONE
  } init_state_e;

  // Pack burst length, burst type and latency into the low mode bits.
  function automatic logic [6:0] mode_field(input logic [2:0] blen,
                                            input logic       btype,
                                            input logic [2:0] clat);
    return {clat, btype, blen};
  endfunction

endpackage

// File: rtl/lpddr_init_timer.sv
`timescale 1ns/1ps
module lpddr_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/lpddr_init_fsm.sv
`timescale 1ns/1ps
module lpddr_init_fsm
  import lpddr_init_pkg::*;
#(
  parameter int T_PWR = 20000,
  parameter int T_RP  = 3,
  parameter int T_RFC = 8,
  parameter int T_MRD = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic             tmr_zero,
  output init_state_e      state_q,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  // The power hold counts every cycle it spends in its own state.
  // Waits after a command also count the command cycle itself.
  localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(T_PWR - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP  - 2);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 2);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);

  init_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (pwr_ok)   state_d = S_PWR;
      S_PWR:   if (tmr_zero) state_d = S_CKE;
      S_CKE:                 state_d = S_PRE;
      S_PRE:                 state_d = S_RP;
      S_RP:    if (tmr_zero) state_d = S_REF1;
      S_REF1:                state_d = S_RFC1;
      S_RFC1:  if (tmr_zero) state_d = S_REF2;
      S_REF2:                state_d = S_RFC2;
      S_RFC2:  if (tmr_zero) state_d = S_MRS;
      S_MRS:                 state_d = S_MRD1;
      S_MRD1:  if (tmr_zero) state_d = S_EMRS;
      S_EMRS:                state_d = S_MRD2;
      S_MRD2:  if (tmr_zero) state_d = S_DONE;
      S_DONE:                state_d = S_DONE;
      default:               state_d = S_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      S_PWR:           tmr_val = LD_PWR;
      S_RP:            tmr_val = LD_RP;
      S_RFC1, S_RFC2:  tmr_val = LD_RFC;
      S_MRD1, S_MRD2:  tmr_val = LD_MRD;
      default:         tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/lpddr_init_cmdgen.sv
`timescale 1ns/1ps
module lpddr_init_cmdgen
  import lpddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  init_state_e       state_q,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [ADDR_W-1:0] cfg_ext_word,
  input  logic [2:0]        host_cmd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BA_W-1:0]   host_ba,
  input  logic              host_dq_oe,
  output logic              cke,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              dq_oe,
  output logic              done
);

  localparam int ALL_BANK_BIT = 10;
  localparam logic [ADDR_W-1:0] PRE_ALL_WORD = ADDR_W'(1) << ALL_BANK_BIT;
  localparam logic [BA_W-1:0]   EXT_BANK     = BA_W'(2);

  logic [ADDR_W-1:0] mode_word;

  assign mode_word = ADDR_W'(mode_field(cfg_burst_len, cfg_burst_type, cfg_cas_lat));

  always_comb begin
    cke   = 1'b1;
    cmd   = CMD_NOP;
    addr  = '0;
    ba    = '0;
    dq_oe = 1'b0;
    done  = 1'b0;
    case (state_q)
      S_IDLE, S_PWR: cke = 1'b0;
      S_PRE: begin
        cmd  = CMD_PRE;
        addr = PRE_ALL_WORD;
      end
      S_REF1, S_REF2: cmd = CMD_REF;
      S_MRS: begin
        cmd  = CMD_MRS;
        addr = mode_word;
      end
      S_EMRS: begin
        cmd  = CMD_MRS;
        addr = cfg_ext_word;
        ba   = EXT_BANK;
      end
      S_DONE: begin
        cmd   = host_cmd;
        addr  = host_addr;
        ba    = host_ba;
        dq_oe = host_dq_oe;
        done  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpddr_init_seq.sv
`timescale 1ns/1ps
module lpddr_init_seq
  import lpddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int T_PWR  = 20000,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 8,
  parameter int T_MRD  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [ADDR_W-1:0] cfg_ext_word,
  input  logic [2:0]        host_cmd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BA_W-1:0]   host_ba,
  input  logic              host_dq_oe,
  output logic              cke,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              dq_oe,
  output logic              init_done
);

  localparam int MAX_T = (T_PWR > T_RFC) ? T_PWR : T_RFC;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  init_state_e            state_q;
  logic                   tmr_load;
  logic [CNT_W-1:0]       tmr_val;
  logic                   tmr_zero;

  // Assertion takes effect at once; release waits for two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  lpddr_init_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  lpddr_init_fsm #(
    .T_PWR (T_PWR), .T_RP (T_RP), .T_RFC (T_RFC), .T_MRD (T_MRD), .CNT_W (CNT_W)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pwr_ok   (pwr_ok),
    .tmr_zero (tmr_zero),
    .state_q  (state_q),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  lpddr_init_cmdgen #(.ADDR_W(ADDR_W), .BA_W(BA_W)) cmdgen_i (
    .state_q        (state_q),
    .cfg_burst_len  (cfg_burst_len),
    .cfg_burst_type (cfg_burst_type),
    .cfg_cas_lat    (cfg_cas_lat),
    .cfg_ext_word   (cfg_ext_word),
    .host_cmd       (host_cmd),
    .host_addr      (host_addr),
    .host_ba        (host_ba),
    .host_dq_oe     (host_dq_oe),
    .cke            (cke),
    .cmd            (cmd),
    .addr           (addr),
    .ba             (ba),
    .dq_oe          (dq_oe),
    .done           (init_done)
  );

endmodule

// File: rtl/lpddr_init_chk.sv
`timescale 1ns/1ps
module lpddr_init_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              dq_oe,
  input logic              init_done,
  input logic [2:0]        host_cmd
);

  assert_cmd_needs_cke_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 3'd0) |-> cke);

  assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == 3'd1) |-> (addr[10] && ba == '0));

  assert_single_cycle_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd != 3'd0) |=> (cmd == 3'd0));

  assert_mode_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == 3'd3 && ba == '0) |-> (addr[ADDR_W-1:7] == '0));

  assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !dq_oe);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_cke_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  assert_host_cmd_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == host_cmd && cke));

endmodule

bind lpddr_init_seq lpddr_init_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cmd       (cmd),
  .addr      (addr),
  .ba        (ba),
  .dq_oe     (dq_oe),
  .init_done (init_done),
  .host_cmd  (host_cmd)
);

// File: tb/lpddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module lpddr_init_seq_tb_top;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int T_PWR  = 40;
  localparam int T_RP   = 4;
  localparam int T_RFC  = 7;
  localparam int T_MRD  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pwr_ok = 1'b0;
  logic [2:0]        cfg_burst_len = '0;
  logic              cfg_burst_type = 1'b0;
  logic [2:0]        cfg_cas_lat = '0;
  logic [ADDR_W-1:0] cfg_ext_word = '0;
  logic [2:0]        host_cmd = '0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [BA_W-1:0]   host_ba = '0;
  logic              host_dq_oe = 1'b0;
  logic              cke;
  logic [2:0]        cmd;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   ba;
  logic              dq_oe;
  logic              init_done;

  int nchecks = 0;
  int nerr    = 0;

  always #5 clk = ~clk;

  lpddr_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .T_PWR(T_PWR), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .cfg_burst_len(cfg_burst_len), .cfg_burst_type(cfg_burst_type),
    .cfg_cas_lat(cfg_cas_lat), .cfg_ext_word(cfg_ext_word),
    .host_cmd(host_cmd), .host_addr(host_addr), .host_ba(host_ba), .host_dq_oe(host_dq_oe),
    .cke(cke), .cmd(cmd), .addr(addr), .ba(ba), .dq_oe(dq_oe), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sample index, counted from the edge that first sees pwr_ok, of command k.
  function automatic int exp_idx(input int k);
    int t;
    t = T_PWR + 2;
    if (k >= 1) t += T_RP;
    if (k >= 2) t += T_RFC;
    if (k >= 3) t += T_RFC;
    if (k >= 4) t += T_MRD;
    if (k >= 5) t += T_MRD;
    return t;
  endfunction

  function automatic logic [2:0] exp_code(input int k);
    case (k)
      0: return 3'd1;
      1, 2: return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input int k);
    case (k)
      0: return ADDR_W'(1) << 10;
      3: return ADDR_W'({cfg_cas_lat, cfg_burst_type, cfg_burst_len});
      4: return cfg_ext_word;
      default: return '0;
    endcase
  endfunction

  task automatic chk_idle(input string req);
    chk(cke == 1'b0, req, "cke", 32'(cke), 0);
    chk(cmd == 3'd0, req, "cmd", 32'(cmd), 0);
    chk(addr == '0 && ba == '0, req, "addr/ba", {addr, ba}, 0);
    chk(dq_oe == 1'b0 && init_done == 1'b0, req, "oe/done", {dq_oe, init_done}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    pwr_ok = 1'b0;
    #1 chk_idle("R1");
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
  endtask

  // Runs the sequence from pwr_ok; aborts with reset at sample abort_at (0 = never).
  task automatic run_init(input int abort_at, input int pre_wait);
    int nev;
    bit done_seen;
    nev = 0;
    done_seen = 1'b0;
    repeat (pre_wait) begin
      @(negedge clk);
      chk(cke == 1'b0 && cmd == 3'd0, "R2", "idle before pwr_ok", {cke, cmd}, 0);
    end
    @(negedge clk);
    pwr_ok = 1'b1;
    for (int i = 1; i <= exp_idx(5) + 5 && !done_seen; i++) begin
      @(negedge clk);
      if (i == abort_at) begin
        rst_n  = 1'b0;
        pwr_ok = 1'b0;
        #1 chk_idle("R10");
        repeat (2) @(negedge clk);
        chk_idle("R10");
        rst_n = 1'b1;
        return;
      end
      if (!init_done)
        chk(dq_oe == 1'b0, "R8", "dq_oe during init", 32'(dq_oe), 0);
      if (i <= T_PWR)
        chk(cke == 1'b0 && cmd == 3'd0, "R2", "power hold", {cke, cmd}, 0);
      else
        chk(cke == 1'b1, (i == T_PWR + 1) ? "R3" : "R8", "cke high", 32'(cke), 1);
      if (init_done) begin
        done_seen = 1'b1;
        chk(i == exp_idx(5), "R8", "done index", i, exp_idx(5));
        chk(nev == 5, "R4", "command count", nev, 5);
      end else if (cmd != 3'd0) begin
        if (nev >= 5) begin
          chk(1'b0, "R4", "extra command", 32'(cmd), 0);
        end else begin
          case (nev)
            0: chk(i == exp_idx(0), "R3", "PRE index", i, exp_idx(0));
            1: chk(i == exp_idx(1), "R4", "REF1 index", i, exp_idx(1));
            2: chk(i == exp_idx(2), "R5", "REF2 index", i, exp_idx(2));
            3: chk(i == exp_idx(3), "R5", "MRS index", i, exp_idx(3));
            default: chk(i == exp_idx(4), "R7", "EMRS index", i, exp_idx(4));
          endcase
          chk(cmd == exp_code(nev), (nev == 0) ? "R3" : (nev < 3) ? "R4" : "R6",
              "code", 32'(cmd), 32'(exp_code(nev)));
          chk(addr == exp_addr(nev), (nev == 4) ? "R7" : (nev == 3) ? "R6" : "R3",
              "addr", 32'(addr), 32'(exp_addr(nev)));
          chk(ba == ((nev == 4) ? BA_W'(2) : BA_W'(0)), (nev == 4) ? "R7" : "R6",
              "ba", 32'(ba), (nev == 4) ? 2 : 0);
          nev++;
        end
      end
    end
    chk(done_seen, "R8", "init_done reached", 32'(done_seen), 1);
  endtask

  task automatic host_phase(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      host_cmd   = 3'($urandom % 5);
      host_addr  = ADDR_W'($urandom);
      host_ba    = BA_W'($urandom);
      host_dq_oe = 1'($urandom);
      pwr_ok     = 1'($urandom);
      #1;
      chk(cmd == host_cmd && addr == host_addr && ba == host_ba && dq_oe == host_dq_oe,
          "R9", "pass-through", {cmd, addr, ba, dq_oe}, {host_cmd, host_addr, host_ba, host_dq_oe});
      chk(init_done && cke, "R9", "done/cke held", {init_done, cke}, 3);
    end
  endtask

  initial begin
    #1ms;
    nerr++;
    nchecks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    do_reset();
    // R2: pwr_ok held low for a long time leaves the block idle
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      chk(cke == 1'b0 && cmd == 3'd0 && !init_done, "R2", "wait without pwr_ok", {cke, cmd}, 0);
    end
    // Directed corner: every mode field at its maximum, all-ones extended word
    cfg_burst_len = 3'd7; cfg_burst_type = 1'b1; cfg_cas_lat = 3'd7;
    cfg_ext_word = '1;
    run_init(0, 2);
    host_phase(30);
    // Directed corner: reset on the PRE cycle, then clean rerun
    do_reset();
    cfg_burst_len = 3'd0; cfg_burst_type = 1'b0; cfg_cas_lat = 3'd0; cfg_ext_word = '0;
    run_init(exp_idx(0), 4);
    run_init(0, 4);
    host_phase(5);
    // Random runs, about half aborted at a random point
    for (int r = 0; r < 8; r++) begin
      do_reset();
      cfg_burst_len  = 3'($urandom);
      cfg_burst_type = 1'($urandom);
      cfg_cas_lat    = 3'($urandom);
      cfg_ext_word   = ADDR_W'($urandom);
      if ($urandom % 2 == 1) begin
        run_init(1 + int'($urandom % exp_idx(5)), 4 + int'($urandom % 6));
        chk(init_done == 1'b0, "R10", "done low after abort", 32'(init_done), 0);
      end
      run_init(0, 4 + int'($urandom % 6));
      host_phase(10);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

endmodule